// File: doc/BRIEF.md
# Serial Slave Front End with Pause and Strap Addressing

This block is the serial-side front end of a multi-channel register device. It watches a serial clock, an active-low chip select, a serial data input and an active-low pause input, all asynchronous to the system clock. It brings them into the system clock domain through two-flop synchronizers and finds serial clock edges by comparing the synchronized level with its value one cycle earlier. For this to work, the system clock must run at least four times faster than the serial clock.

Each frame begins with a command byte. Its top two bits are a fixed device-type code. The next two bits must equal the two strap inputs. The low four bits are an opcode. When the command matches, every complete byte is handed to the register back end as a one-cycle strobe. If the opcode's top bit is set, the frame is a read: the block fetches a byte from the back end at each byte boundary and shifts it out on the serial output. When the command does not match, the rest of the frame is ignored.

The pause input freezes a transfer in the middle of a byte and keeps the bits already shifted. Raising chip select aborts the frame at any point.

FSM states: `ST_ARMED` (after reset, waiting to see chip select high), `ST_IDLE` (deselected), `ST_CMD` (receiving the command byte), `ST_DATA` (frame accepted), `ST_REJECT` (command mismatch). Transitions:
- ARMED→IDLE when chip select is high.
- IDLE→CMD when chip select is low.
- CMD→DATA on a matching command byte.
- CMD→REJECT on a mismatching command byte.
- CMD/DATA/REJECT→IDLE when chip select is high.

Top module: `spi_hold_slave`

## Requirements
- R1: Serial input is sampled on each rising serial clock edge, most significant bit first. Each completed byte of an accepted frame appears on `rx_data_o` with `rx_valid_o` high for exactly one system clock cycle.
- R2: The command byte layout is bits [7:6] = device type (default 2'b10), bits [5:4] = strap address, bits [3:0] = opcode. When bits [7:4] equal {device type, `strap_i`}, the command byte itself is delivered with `rx_first_o` = 1. Later bytes are delivered with `rx_first_o` = 0.
- R3: If bits [7:4] of the command byte do not match, no byte of that frame is delivered and `sdo_oe_o` stays low until chip select rises.
- R4: If opcode bit 3 is 1 (a read), `tx_data_i` is captured at the end of the command byte and at the end of every later byte, and `tx_load_o` pulses once for each capture. The captured byte is driven on `sdo_o` MSB first, and a new bit is presented after each falling serial clock edge. `sdo_oe_o` is high during the data phase of the read.
- R5: While chip select is high, `sdo_oe_o` is low and the block is idle.
- R6: After reset, all traffic is ignored until chip select has been seen high and then low.
- R7: Pulling `hold_n_i` low while the serial clock is low pauses the transfer. Serial clock edges during the pause change no received bit, no bit position and no output bit.
- R8: A low pulse on `hold_n_i` that begins and ends while the serial clock is high has no effect on the transfer.
- R9: The transfer resumes when `hold_n_i` returns high while the serial clock is low, and it continues at the bit where it stopped.
- R10: Raising chip select in the middle of a byte discards that partial byte. The next frame starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data input |
| hold_n_i | input | 1 | Pause request, active low |
| strap_i | input | 2 | Static address straps |
| tx_data_i | input | 8 | Read byte supplied by the back end |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Serial output drive enable (low = high impedance) |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte |
| rx_first_o | output | 1 | Marks the received byte as the command byte |
| tx_load_o | output | 1 | One-cycle pulse when `tx_data_i` is captured |

## Verification
The assertions assume that the serial clock runs at most a quarter of the system clock rate. They also assume that the pause input changes only while the serial clock level is steady, never in the same cycle as a serial clock edge. On these assumptions, a completed byte can never strobe twice in a row, and a pause can never overlap a processed edge. The stimulus holds each serial clock phase for six system cycles, and it moves the pause input only in the middle of a phase. The glitch test keeps its four-cycle pulse inside a single high phase.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    typedef enum logic [2:0] {
        ST_ARMED,
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_REJECT
    } slv_state_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_hold_pkg::*;
#(
    parameter int TYPE_W = 2,
    parameter int ADDR_W = 2,
    parameter int OP_W   = 4,
    parameter logic [TYPE_W-1:0] DEV_TYPE = 2'b10,
    localparam int BYTE_W = TYPE_W + ADDR_W + OP_W,
    localparam int CNT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic              hold_s,
    input  logic [ADDR_W-1:0] strap_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_first_o,
    output logic              tx_load_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    slv_state_e state_q, state_d;

    logic              sck_q;
    logic              paused_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic              is_read_q;

    logic              sck_rise, sck_fall, live, byte_done, cmd_match;
    logic [BYTE_W-1:0] next_byte;

    assign sck_rise  = sck_s & ~sck_q;
    assign sck_fall  = ~sck_s & sck_q;
    assign live      = ~csn_s & ~paused_q;
    assign next_byte = {shift_q[BYTE_W-2:0], sdi_s};
    assign byte_done = live && sck_rise && (bit_cnt_q == LAST_BIT);
    assign cmd_match = next_byte[BYTE_W-1:OP_W] == {DEV_TYPE, strap_i};
    assign sdo_oe_o  = (state_q == ST_DATA) && is_read_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  if (csn_s) state_d = ST_IDLE;
            ST_IDLE:   if (!csn_s) state_d = ST_CMD;
            ST_CMD: begin
                if (csn_s)          state_d = ST_IDLE;
                else if (byte_done) state_d = cmd_match ? ST_DATA : ST_REJECT;
            end
            ST_DATA:   if (csn_s) state_d = ST_IDLE;
            ST_REJECT: if (csn_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            paused_q   <= 1'b0;
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            tx_sh_q    <= '0;
            is_read_q  <= 1'b0;
            sdo_o      <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            rx_first_o <= 1'b0;
            tx_load_o  <= 1'b0;
        end else begin
            sck_q      <= sck_s;
            rx_valid_o <= 1'b0;
            tx_load_o  <= 1'b0;
            if (csn_s) begin
                paused_q  <= 1'b0;
                bit_cnt_q <= '0;
                is_read_q <= 1'b0;
            end else begin
                if (!paused_q && !hold_s && !sck_s)     paused_q <= 1'b1;
                else if (paused_q && hold_s && !sck_s)  paused_q <= 1'b0;

                if (live && (state_q == ST_CMD || state_q == ST_DATA)) begin
                    if (sck_rise) begin
                        shift_q   <= next_byte;
                        bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
                        if (bit_cnt_q == LAST_BIT) begin
                            if (state_q == ST_CMD && cmd_match) begin
                                rx_valid_o <= 1'b1;
                                rx_data_o  <= next_byte;
                                rx_first_o <= 1'b1;
                                is_read_q  <= next_byte[OP_W-1];
                                if (next_byte[OP_W-1]) begin
                                    tx_sh_q   <= tx_data_i;
                                    tx_load_o <= 1'b1;
                                end
                            end else if (state_q == ST_DATA) begin
                                rx_valid_o <= 1'b1;
                                rx_data_o  <= next_byte;
                                rx_first_o <= 1'b0;
                                if (is_read_q) begin
                                    tx_sh_q   <= tx_data_i;
                                    tx_load_o <= 1'b1;
                                end
                            end
                        end
                    end
                    if (sck_fall && state_q == ST_DATA && is_read_q) begin
                        sdo_o   <= tx_sh_q[BYTE_W-1];
                        tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R5: deselect releases the output driver
    p_deselect_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !sdo_oe_o);

    // R1: a byte strobe never lasts two cycles
    p_rx_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R7: no byte completes while paused
    p_no_rx_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_q && $past(paused_q)) |-> !rx_valid_o);

    // R7: bit position frozen while paused and selected
    p_cnt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(paused_q) && $past(!csn_s)) |-> $stable(bit_cnt_q));

    // R6: nothing happens before the first select cycle
    p_armed_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (!rx_valid_o && !sdo_oe_o && !tx_load_o));

    // R3: rejected frames never drive the output
    p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECT) |-> (!sdo_oe_o && !rx_valid_o));
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
    parameter logic [1:0] DEV_TYPE = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       csn_i,
    input  logic       sdi_i,
    input  logic       hold_n_i,
    input  logic [1:0] strap_i,
    input  logic [7:0] tx_data_i,
    output logic       sdo_o,
    output logic       sdo_oe_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rx_first_o,
    output logic       tx_load_o
);
    logic [3:0] raw_in, sync_out;

    assign raw_in = {sck_i, csn_i, sdi_i, hold_n_i};

    // csn resets low so a select held low through reset is not taken as a fall
    spi_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    spi_frame_fsm #(.TYPE_W(2), .ADDR_W(2), .OP_W(4), .DEV_TYPE(DEV_TYPE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (sync_out[3]),
        .csn_s      (sync_out[2]),
        .sdi_s      (sync_out[1]),
        .hold_s     (sync_out[0]),
        .strap_i    (strap_i),
        .tx_data_i  (tx_data_i),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .rx_first_o (rx_first_o),
        .tx_load_o  (tx_load_o)
    );
endmodule

// File: tb/tb_spi_hold_slave.sv
module tb_spi_hold_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam logic [1:0] STRAP = 2'b01;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b0, sdi = 1'b0, hold_n = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic sdo, sdo_oe, rx_valid, rx_first, tx_load;
    logic [7:0] rx_data;

    int total = 0, bad = 0;
    string cur_req = "R1";
    logic [8:0] exp_q[$];
    logic [7:0] fb[4];
    logic [7:0] fr[4];
    int loads = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_hold_slave dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
        .hold_n_i(hold_n), .strap_i(STRAP), .tx_data_i(tx_data),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rx_valid_o(rx_valid),
        .rx_data_o(rx_data), .rx_first_o(rx_first), .tx_load_o(tx_load)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && tx_load) loads++;
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL %s actual=%h expected=none (unexpected byte)", cur_req, {rx_first, rx_data});
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(cur_req, {23'd0, rx_first, rx_data}, {23'd0, e});
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input int hold_at, input int glitch_at,
                             output logic [7:0] rd);
        for (int i = 0; i < 8; i++) begin
            sdi = b[7-i];
            if (i == hold_at) begin
                wait_clk(HALF);
                hold_n = 1'b0;
                wait_clk(HALF);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; sdi = ~sdi; wait_clk(HALF);
                    sck = 1'b0; wait_clk(HALF);
                end
                sdi = b[7-i];
                hold_n = 1'b1;
            end
            wait_clk(HALF);
            rd[7-i] = sdo;
            sck = 1'b1;
            if (i == glitch_at) begin
                wait_clk(1); hold_n = 1'b0; wait_clk(4); hold_n = 1'b1;
                wait_clk(HALF - 5);
            end else begin
                wait_clk(HALF);
            end
            sck = 1'b0;
        end
    endtask

    task automatic run_frame(input int n, input int hb, input int hbit,
                             input int gb, input int gbit, input logic oe_exp, input string oe_req);
        logic acc;
        acc = (fb[0][7:4] == {2'b10, STRAP});
        if (acc)
            for (int j = 0; j < n; j++) exp_q.push_back({(j == 0), fb[j]});
        csn = 1'b0;
        wait_clk(HALF);
        for (int j = 0; j < n; j++) begin
            logic [7:0] r;
            send_byte(fb[j], (j == hb) ? hbit : -1, (j == gb) ? gbit : -1, r);
            fr[j] = r;
        end
        wait_clk(HALF);
        chk(oe_req, {31'd0, sdo_oe}, {31'd0, oe_exp});
        csn = 1'b1;
        wait_clk(4 * HALF);
        chk("R5", {31'd0, sdo_oe}, 32'd0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        cur_req = "R6";
        chk("R6", {30'd0, sdo_oe, rx_valid}, 32'd0);
        begin
            logic [7:0] r;
            send_byte(8'h92, -1, -1, r);   // select held low since reset: ignored
            send_byte(8'h5A, -1, -1, r);
        end
        wait_clk(HALF);
        chk("R6", {31'd0, sdo_oe}, 32'd0);
        csn = 1'b1;
        wait_clk(4 * HALF);

        // plain write frame
        cur_req = "R1 R2";
        fb[0] = 8'h92; fb[1] = 8'h5A; fb[2] = 8'hC3;
        run_frame(3, -1, 0, -1, 0, 1'b0, "R2");

        // same frame with a mid-byte pause
        cur_req = "R7 R9";
        run_frame(3, 1, 3, -1, 0, 1'b0, "R7");
        cur_req = "R9";
        run_frame(3, 2, 0, -1, 0, 1'b0, "R9");

        // pause pulse entirely inside a high phase
        cur_req = "R8";
        run_frame(3, -1, 0, 1, 5, 1'b0, "R8");

        // read frame
        cur_req = "R4";
        tx_data = 8'hA5;
        loads = 0;
        fb[0] = 8'h99; fb[1] = 8'h00; fb[2] = 8'h00;
        run_frame(3, -1, 0, -1, 0, 1'b1, "R4");
        chk("R4", {24'd0, fr[1]}, 32'h0000_00A5);
        chk("R4", {24'd0, fr[2]}, 32'h0000_00A5);
        chk("R4", loads, 32'd3);

        // read with pause inside the outgoing byte
        cur_req = "R7";
        tx_data = 8'h3C;
        run_frame(2, 1, 4, -1, 0, 1'b1, "R4");
        chk("R7", {24'd0, fr[1]}, 32'h0000_003C);

        // mismatching address and mismatching type
        cur_req = "R3";
        fb[0] = 8'hA9; fb[1] = 8'h77;
        run_frame(2, -1, 0, -1, 0, 1'b0, "R3");
        fb[0] = 8'h59;
        run_frame(2, -1, 0, -1, 0, 1'b0, "R3");

        // abort mid-byte, then a clean frame
        cur_req = "R10";
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 5; i++) begin
            sdi = i[0]; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
        csn = 1'b1;
        wait_clk(4 * HALF);
        fb[0] = 8'h92; fb[1] = 8'h11;
        run_frame(2, -1, 0, -1, 0, 1'b0, "R10");

        wait_clk(10);
        chk("R1", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule